// File: doc/BRIEF.md
# Power-on and low-voltage reset sequencer

This block is the digital half of a supply supervisor. Four comparator flags arrive from analog circuits. They report whether the supply sits above the power-on rise threshold, above the power-on fall threshold, above a high warning level and above a low detection level. Each flag is synchronized and debounced on a free-running slow clock. A state machine then turns the flags into an active-low internal reset, an oscillator enable, a CPU-ready indication and a one-cycle low-voltage interrupt.

Low-voltage detection takes part only in the interrupt-and-reset mode, which is picked by a 2-bit option field. In that mode a drop below the high level is only a warning and raises an interrupt. A drop below the low level forces reset. The supply may return above the high level without reaching the low level, and then operation simply continues. A 2-bit configuration register, with a level-select bit and a mode bit, can be read and written from the bus. Hardware sets both bits when the interrupt fires, and the register reloads from the option inputs while the supply is off.

Every wait is a parameter counted in slow-clock cycles. There is a power-on wait, a shorter wait after a low-voltage reset and an oscillator stabilization wait. One shared down-counter times all three.

Top module: `por_lvd_seq`

## Requirements
- R1: While `rst_n_i` is low and right after it rises, `rst_n_o`, `osc_en_o`, `cpu_rdy_o` and `lvd_irq_o` are 0. `cfg_o` equals {`opt_mode_i[0]`, `opt_lvl_i`}: bit 1 is the mode bit and bit 0 is the level-select bit.
- R2: When the supply rises (rise and fall flags go to 1 together), `rst_n_o` and `osc_en_o` rise exactly FILT_CYC+POR_WAIT_CYC+3 clock edges after the first edge that sees the flags.
- R3: `cpu_rdy_o` rises OSC_WAIT_CYC+1 edges after `rst_n_o` rises, and it is 0 whenever `rst_n_o` is 0. `osc_en_o` is also 0 whenever `rst_n_o` is 0.
- R4: Interrupt-and-reset mode is `opt_mode_i` = 2'b10. In that mode, while out of reset and with `cfg_o[1]`=0, a fall of the high-level flag gives one single-cycle `lvd_irq_o` pulse FILT_CYC+2 edges later, and `rst_n_o` stays 1.
- R5: In the cycle the interrupt fires, `cfg_o` becomes 2'b11. While `cfg_o[1]`=1, later falls of the high-level flag raise no interrupt. Writing 0 to bit 1 re-arms the interrupt.
- R6: If the high-level flag returns to 1 while the low-level flag stays 1, there is no reset and `cpu_rdy_o` stays 1.
- R7: In mode 2'b10, a fall of the low-level flag while out of reset drives `rst_n_o`, `osc_en_o` and `cpu_rdy_o` to 0 FILT_CYC+2 edges later.
- R8: After a low-voltage reset, reset holds until the high-level flag is back. It is then released FILT_CYC+LVD_WAIT_CYC+3 edges after the high-level flag rises. If the high-level flag drops during that wait, the block returns to waiting for it.
- R9: A fall of the power-on fall flag forces reset from any state, with priority over every other event. The release that follows takes the full power-on wait of R2.
- R10: A bus write (`wr_en_i`, `wr_data_i` with bit 1 = mode bit and bit 0 = level select) updates `cfg_o` on the next edge while `rst_n_o` is 1. The write is ignored while `rst_n_o` is 0.
- R11: While the supply is off (power-on fall flag low), `cfg_o` reloads to {`opt_mode_i[0]`, `opt_lvl_i`}.
- R12: With `opt_mode_i` other than 2'b10, the high-level and low-level flags have no effect: no interrupt and no reset.
- R13: A flag change that lasts fewer than FILT_CYC cycles after synchronization is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running slow clock |
| rst_n_i | input | 1 | Asynchronous active-low reset of the controller flops |
| por_rise_i | input | 1 | Supply above power-on rise threshold |
| por_fall_i | input | 1 | Supply above power-on fall threshold |
| lvd_hi_i | input | 1 | Supply above high (warning) detection level |
| lvd_lo_i | input | 1 | Supply above low (reset) detection level |
| opt_mode_i | input | 2 | Option mode field; 2'b10 selects interrupt-and-reset |
| opt_lvl_i | input | 1 | Option value for the level-select bit |
| wr_en_i | input | 1 | Configuration register write strobe |
| wr_data_i | input | 2 | Write data: bit 1 mode bit, bit 0 level select |
| rst_n_o | output | 1 | Internal reset, active low |
| osc_en_o | output | 1 | Oscillator enable |
| cpu_rdy_o | output | 1 | Oscillator settled, CPU may run |
| lvd_irq_o | output | 1 | Single-cycle low-voltage interrupt |
| cfg_o | output | 2 | Configuration register: bit 1 mode bit, bit 0 level select |

## Verification
The bench predicts the exact cycle of every reset edge, ready edge and interrupt pulse from the three wait lengths. A design that mixed up the power-on and low-voltage release delays, or that kept counting a wait after the power-on fall flag dropped, would report an event at the wrong cycle. The bench pulls the high-level flag down again in the middle of the low-voltage wait, so a design that released reset anyway shows an unexpected release. It also re-drops the high-level flag while the interrupt is disarmed, writes the register during reset and applies a glitch shorter than the filter. A wrong design would then show a repeated interrupt, a changed register value or a spurious reset.

// File: rtl/por_lvd_pkg.sv
package por_lvd_pkg;

  typedef enum logic [2:0] {
    ST_OFF      = 3'd0,
    ST_POR_WAIT = 3'd1,
    ST_LVD_HOLD = 3'd2,
    ST_LVD_WAIT = 3'd3,
    ST_OSC_WAIT = 3'd4,
    ST_RUN      = 3'd5
  } seq_state_e;

  // bit 1: mode bit (1 = interrupt already taken), bit 0: level select
  typedef struct packed {
    logic mode_bit;
    logic lvl_sel;
  } lvd_cfg_t;

  localparam logic [1:0] MODE_INT_RST = 2'b10;

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // reset released in these states
  function automatic logic is_running(input seq_state_e s);
    return (s == ST_OSC_WAIT) || (s == ST_RUN);
  endfunction

  function automatic logic is_timed(input seq_state_e s);
    return (s == ST_POR_WAIT) || (s == ST_LVD_WAIT) || (s == ST_OSC_WAIT);
  endfunction

  // wait length loaded on entry to a timed state
  function automatic int unsigned wait_for(input seq_state_e s, input int unsigned por_w,
                                           input int unsigned lvd_w, input int unsigned osc_w);
    case (s)
      ST_POR_WAIT: return por_w;
      ST_LVD_WAIT: return lvd_w;
      ST_OSC_WAIT: return osc_w;
      default:     return 0;
    endcase
  endfunction

endpackage

// File: rtl/pl_flag_filter.sv
module pl_flag_filter #(
  parameter int unsigned FILT_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic raw_i,
  output logic level_o
);
  localparam int unsigned CW = $clog2(FILT_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(FILT_CYC - 1);

  logic          sync1_q, sync2_q, filt_q;
  logic [CW-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      filt_q  <= 1'b0;
      run_q   <= '0;
    end else begin
      sync1_q <= raw_i;
      sync2_q <= sync1_q;
      if (sync2_q == filt_q) begin
        run_q <= '0;
      end else if (run_q == LAST) begin
        filt_q <= sync2_q;
        run_q  <= '0;
      end else begin
        run_q <= run_q + CW'(1);
      end
    end
  end

  assign level_o = filt_q;

  // R13: the filtered level only moves after FILT_CYC differing samples
  p_filt_stable_r13: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (filt_q != $past(filt_q)) |-> ($past(run_q) == LAST));

endmodule

// File: rtl/pl_wait_timer.sv
module pl_wait_timer #(
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_n_i,
  input  logic          load_i,
  input  logic [CW-1:0] val_i,
  output logic          done_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i)              cnt_q <= '0;
    else if (load_i)           cnt_q <= val_i;
    else if (cnt_q != '0)      cnt_q <= cnt_q - CW'(1);
  end

  assign done_o = (cnt_q == '0);

  // R2: an unloaded running count steps down by exactly one
  p_tmr_step_r2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CW'(1)));

endmodule

// File: rtl/pl_cfg_reg.sv
module pl_cfg_reg
  import por_lvd_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_n_i,
  input  logic     load_opt_i,
  input  lvd_cfg_t opt_i,
  input  logic     auto_set_i,
  input  logic     wr_en_i,
  input  lvd_cfg_t wr_data_i,
  output lvd_cfg_t cfg_o
);
  lvd_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i)        cfg_q <= opt_i;
    else if (load_opt_i) cfg_q <= opt_i;
    else if (auto_set_i) cfg_q <= '{mode_bit: 1'b1, lvl_sel: 1'b1};
    else if (wr_en_i)    cfg_q <= wr_data_i;
  end

  assign cfg_o = cfg_q;

  // R5: hardware set wins and lands both bits
  p_auto_set_r5: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (auto_set_i && !load_opt_i) |=> (cfg_q == 2'b11));

endmodule

// File: rtl/pl_seq_fsm.sv
module pl_seq_fsm
  import por_lvd_pkg::*;
#(
  parameter int unsigned POR_WAIT_CYC = 53,
  parameter int unsigned LVD_WAIT_CYC = 2,
  parameter int unsigned OSC_WAIT_CYC = 16,
  parameter int unsigned TW           = 6
) (
  input  logic          clk_i,
  input  logic          rst_n_i,
  input  logic          f_rise_i,
  input  logic          f_fall_i,
  input  logic          f_hi_i,
  input  logic          f_lo_i,
  input  logic          lvd_en_i,
  input  logic          armed_i,
  input  logic          tmr_done_i,
  output logic          tmr_load_o,
  output logic [TW-1:0] tmr_val_o,
  output seq_state_e    state_o,
  output logic          irq_set_o,
  output logic          irq_q_o
);
  seq_state_e st_q, st_n;
  logic       hi_d_q;
  logic       hi_fell;

  always_comb begin
    st_n = st_q;
    case (st_q)
      ST_OFF:      if (f_rise_i && f_fall_i) st_n = ST_POR_WAIT;
      ST_POR_WAIT: if (tmr_done_i) st_n = (lvd_en_i && !f_hi_i) ? ST_LVD_HOLD : ST_OSC_WAIT;
      ST_LVD_HOLD: if (f_hi_i) st_n = ST_LVD_WAIT;
      ST_LVD_WAIT: begin
        if (!f_hi_i)         st_n = ST_LVD_HOLD;
        else if (tmr_done_i) st_n = ST_OSC_WAIT;
      end
      ST_OSC_WAIT, ST_RUN: begin
        if (lvd_en_i && !f_lo_i)                  st_n = ST_LVD_HOLD;
        else if (st_q == ST_OSC_WAIT && tmr_done_i) st_n = ST_RUN;
      end
      default: st_n = ST_OFF;
    endcase
    if (!f_fall_i) st_n = ST_OFF;
  end

  assign tmr_load_o = (st_n != st_q) && is_timed(st_n);
  assign tmr_val_o  = TW'(wait_for(st_n, POR_WAIT_CYC, LVD_WAIT_CYC, OSC_WAIT_CYC));

  assign hi_fell   = hi_d_q && !f_hi_i;
  assign irq_set_o = lvd_en_i && armed_i && hi_fell && is_running(st_q) && is_running(st_n);

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      st_q    <= ST_OFF;
      hi_d_q  <= 1'b0;
      irq_q_o <= 1'b0;
    end else begin
      st_q    <= st_n;
      hi_d_q  <= f_hi_i;
      irq_q_o <= irq_set_o;
    end
  end

  assign state_o = st_q;

  // R9: power-on fall beats every other event
  p_fall_prio_r9: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !f_fall_i |=> (st_q == ST_OFF));

  // R7: low level lost while running forces the hold state
  p_lo_reset_r7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (lvd_en_i && !f_lo_i && f_fall_i && is_running(st_q)) |=> (st_q == ST_LVD_HOLD));

  // R8: no release out of the low-voltage path without the high level present
  p_hold_needs_hi_r8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (st_q == ST_LVD_HOLD && !f_hi_i) |=> (st_q != ST_LVD_WAIT));

endmodule

// File: rtl/por_lvd_seq.sv
module por_lvd_seq
  import por_lvd_pkg::*;
#(
  parameter int unsigned FILT_CYC     = 4,
  parameter int unsigned POR_WAIT_CYC = 53,
  parameter int unsigned LVD_WAIT_CYC = 2,
  parameter int unsigned OSC_WAIT_CYC = 16
) (
  input  logic       clk_i,
  input  logic       rst_n_i,
  input  logic       por_rise_i,
  input  logic       por_fall_i,
  input  logic       lvd_hi_i,
  input  logic       lvd_lo_i,
  input  logic [1:0] opt_mode_i,
  input  logic       opt_lvl_i,
  input  logic       wr_en_i,
  input  logic [1:0] wr_data_i,
  output logic       rst_n_o,
  output logic       osc_en_o,
  output logic       cpu_rdy_o,
  output logic       lvd_irq_o,
  output logic [1:0] cfg_o
);
  localparam int unsigned NFLAG = 4;
  localparam int unsigned TW    = $clog2(max3(POR_WAIT_CYC, LVD_WAIT_CYC, OSC_WAIT_CYC) + 1);

  logic [NFLAG-1:0] raw_flags, filt_flags;
  logic             tmr_load, tmr_done, irq_set, lvd_en, wr_ok;
  logic [TW-1:0]    tmr_val;
  seq_state_e       state;
  lvd_cfg_t         cfg, opt_cfg;

  assign raw_flags = {lvd_lo_i, lvd_hi_i, por_fall_i, por_rise_i};

  for (genvar g = 0; g < NFLAG; g++) begin : g_filt
    pl_flag_filter #(.FILT_CYC(FILT_CYC)) u_filt (
      .clk_i   (clk_i),
      .rst_n_i (rst_n_i),
      .raw_i   (raw_flags[g]),
      .level_o (filt_flags[g])
    );
  end

  assign lvd_en  = (opt_mode_i == MODE_INT_RST);
  assign opt_cfg = '{mode_bit: opt_mode_i[0], lvl_sel: opt_lvl_i};

  pl_wait_timer #(.CW(TW)) u_timer (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_i),
    .load_i  (tmr_load),
    .val_i   (tmr_val),
    .done_o  (tmr_done)
  );

  pl_seq_fsm #(
    .POR_WAIT_CYC (POR_WAIT_CYC),
    .LVD_WAIT_CYC (LVD_WAIT_CYC),
    .OSC_WAIT_CYC (OSC_WAIT_CYC),
    .TW           (TW)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_n_i    (rst_n_i),
    .f_rise_i   (filt_flags[0]),
    .f_fall_i   (filt_flags[1]),
    .f_hi_i     (filt_flags[2]),
    .f_lo_i     (filt_flags[3]),
    .lvd_en_i   (lvd_en),
    .armed_i    (!cfg.mode_bit),
    .tmr_done_i (tmr_done),
    .tmr_load_o (tmr_load),
    .tmr_val_o  (tmr_val),
    .state_o    (state),
    .irq_set_o  (irq_set),
    .irq_q_o    (lvd_irq_o)
  );

  assign rst_n_o   = is_running(state);
  assign osc_en_o  = is_running(state);
  assign cpu_rdy_o = (state == ST_RUN);
  assign wr_ok     = wr_en_i && rst_n_o;

  pl_cfg_reg u_cfg (
    .clk_i      (clk_i),
    .rst_n_i    (rst_n_i),
    .load_opt_i (state == ST_OFF),
    .opt_i      (opt_cfg),
    .auto_set_i (irq_set),
    .wr_en_i    (wr_ok),
    .wr_data_i  (lvd_cfg_t'(wr_data_i)),
    .cfg_o      (cfg)
  );

  assign cfg_o = cfg;

  // R3: nothing runs while reset is held
  p_rdy_in_reset_r3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !rst_n_o |-> (!cpu_rdy_o && !osc_en_o));

  // R4: the interrupt is a single-cycle pulse outside reset
  p_irq_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    lvd_irq_o |=> !lvd_irq_o);

  // R5: register already shows both bits set with the pulse
  p_irq_cfg_r5: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    lvd_irq_o |-> (cfg_o == 2'b11 && rst_n_o));

  // R10: bus writes in reset leave the register alone
  p_wr_ignored_r10: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (wr_en_i && !rst_n_o && state != ST_OFF) |=> $stable(cfg_o));

  // R12: other modes never interrupt
  p_mode_gate_r12: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (opt_mode_i != MODE_INT_RST) |=> !lvd_irq_o);

endmodule

// File: tb/por_lvd_seq_tb.sv
module por_lvd_seq_tb;
  localparam int FILT = 3;
  localparam int PW   = 20;
  localparam int LW   = 12;
  localparam int OW   = 8;

  localparam int EV_ASSERT = 0;
  localparam int EV_REL    = 1;
  localparam int EV_IRQ    = 2;
  localparam int EV_RDY    = 3;

  typedef struct {
    int    kind;
    int    cyc;
    string tag;
  } ev_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       por_rise = 1'b0, por_fall = 1'b0, lvd_hi = 1'b0, lvd_lo = 1'b0;
  logic [1:0] opt_mode = 2'b10;
  logic       opt_lvl = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_data = 2'b00;
  logic       rst_n_o, osc_en_o, cpu_rdy_o, lvd_irq_o;
  logic [1:0] cfg_o;

  int  cyc = 0;
  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 1'b0;
  ev_t exp_q[$];
  logic prev_rst = 1'b0, prev_irq = 1'b0, prev_rdy = 1'b0;

  por_lvd_seq #(
    .FILT_CYC(FILT), .POR_WAIT_CYC(PW), .LVD_WAIT_CYC(LW), .OSC_WAIT_CYC(OW)
  ) u_dut (
    .clk_i(clk), .rst_n_i(rst_n),
    .por_rise_i(por_rise), .por_fall_i(por_fall), .lvd_hi_i(lvd_hi), .lvd_lo_i(lvd_lo),
    .opt_mode_i(opt_mode), .opt_lvl_i(opt_lvl),
    .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rst_n_o(rst_n_o), .osc_en_o(osc_en_o), .cpu_rdy_o(cpu_rdy_o),
    .lvd_irq_o(lvd_irq_o), .cfg_o(cfg_o)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic push_ev(input int kind, input int at, input string tag);
    ev_t e;
    e.kind = kind; e.cyc = at; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic seen_ev(input int kind);
    ev_t e;
    if (exp_q.size() == 0) begin
      check(1'b0, "unexpected event", kind, -1);
    end else begin
      e = exp_q.pop_front();
      check(e.kind == kind, e.tag, kind, e.kind);
      check(e.cyc == cyc, e.tag, cyc, e.cyc);
    end
  endtask

  // monitor: turns output edges into events and scores them
  always @(negedge clk) begin
    if (rst_n) begin
      if (rst_n_o !== prev_rst) seen_ev(rst_n_o ? EV_REL : EV_ASSERT);
      if (lvd_irq_o && !prev_irq) seen_ev(EV_IRQ);
      if (cpu_rdy_o && !prev_rdy) seen_ev(EV_RDY);
    end
    prev_rst = rst_n_o;
    prev_irq = lvd_irq_o;
    prev_rdy = cpu_rdy_o;
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // expected delays, from the requirement text
  function automatic int por_release(input int c);
    return c + 1 + FILT + PW + 3;
  endfunction
  function automatic int lvd_release(input int c);
    return c + 1 + FILT + LW + 3;
  endfunction
  function automatic int after_filter(input int c);
    return c + 1 + FILT + 2;
  endfunction

  task automatic power_up(input string tag);
    int c;
    @(negedge clk);
    por_rise = 1'b1; por_fall = 1'b1; lvd_hi = 1'b1; lvd_lo = 1'b1;
    c = cyc;
    push_ev(EV_REL, por_release(c), tag);
    push_ev(EV_RDY, por_release(c) + OW + 1, {tag, " R3 ready"});
    step(FILT + PW + OW + 12);
  endtask

  initial begin
    int c;
    step(3);
    rst_n = 1'b1;
    step(1);
    // R1 reset state
    check(rst_n_o == 1'b0, "R1 rst_n_o", rst_n_o, 0);
    check(osc_en_o == 1'b0 && cpu_rdy_o == 1'b0, "R1 osc/rdy", {osc_en_o, cpu_rdy_o}, 0);
    check(lvd_irq_o == 1'b0, "R1 irq", lvd_irq_o, 0);
    check(cfg_o == 2'b00, "R1 cfg", cfg_o, 0);

    // R2 power-on release and R3 ready
    power_up("R2 por release");
    check(osc_en_o == 1'b1 && cpu_rdy_o == 1'b1, "R2 osc/rdy up", {osc_en_o, cpu_rdy_o}, 3);

    // R10 write accepted while running
    bus_write(2'b01);
    check(cfg_o == 2'b01, "R10 write accepted", cfg_o, 1);
    bus_write(2'b00);
    check(cfg_o == 2'b00, "R10 write back", cfg_o, 0);

    // R4 warning interrupt, no reset
    @(negedge clk); lvd_hi = 1'b0; c = cyc;
    push_ev(EV_IRQ, after_filter(c), "R4 irq timing");
    step(12);
    check(rst_n_o == 1'b1, "R4 no reset", rst_n_o, 1);
    check(cfg_o == 2'b11, "R5 auto set", cfg_o, 3);

    // R6 recovery without reset
    lvd_hi = 1'b1;
    step(12);
    check(rst_n_o == 1'b1 && cpu_rdy_o == 1'b1, "R6 stays running", {rst_n_o, cpu_rdy_o}, 3);

    // R5 disarmed: no second interrupt
    lvd_hi = 1'b0;
    step(12);
    lvd_hi = 1'b1;
    step(12);
    check(cfg_o == 2'b11, "R5 still set", cfg_o, 3);

    // R5 re-arm by write, then interrupt again
    bus_write(2'b00);
    check(cfg_o == 2'b00, "R5 rearm write", cfg_o, 0);
    @(negedge clk); lvd_hi = 1'b0; c = cyc;
    push_ev(EV_IRQ, after_filter(c), "R5 rearmed irq");
    step(12);

    // R13 short glitch on low flag ignored
    lvd_lo = 1'b0;
    step(FILT - 1);
    lvd_lo = 1'b1;
    step(12);
    check(rst_n_o == 1'b1, "R13 glitch ignored", rst_n_o, 1);

    // R7 low-level reset
    @(negedge clk); lvd_lo = 1'b0; c = cyc;
    push_ev(EV_ASSERT, after_filter(c), "R7 lvd reset");
    step(FILT + 5);
    check(osc_en_o == 1'b0 && cpu_rdy_o == 1'b0, "R7 osc/rdy low", {osc_en_o, cpu_rdy_o}, 0);

    // R10 write ignored in reset
    bus_write(2'b00);
    check(cfg_o == 2'b11, "R10 write ignored", cfg_o, 3);

    // R8 hold until high level, restart if it drops in the wait
    lvd_lo = 1'b1;
    step(20);
    check(rst_n_o == 1'b0, "R8 hold without hi", rst_n_o, 0);
    lvd_hi = 1'b1;
    step(FILT + 3);
    lvd_hi = 1'b0;
    step(30);
    check(rst_n_o == 1'b0, "R8 wait restarted", rst_n_o, 0);
    @(negedge clk); lvd_hi = 1'b1; c = cyc;
    push_ev(EV_REL, lvd_release(c), "R8 lvd release");
    push_ev(EV_RDY, lvd_release(c) + OW + 1, "R8 R3 ready");
    step(FILT + LW + OW + 12);
    check(cfg_o == 2'b11, "R10 value kept", cfg_o, 3);

    // R9 power-on fall during low-voltage wait
    @(negedge clk); lvd_hi = 1'b0; lvd_lo = 1'b0; c = cyc;
    push_ev(EV_ASSERT, after_filter(c), "R9 lvd reset");
    step(15);
    lvd_hi = 1'b1; lvd_lo = 1'b1;
    step(FILT + 5);
    por_rise = 1'b0; por_fall = 1'b0;
    step(LW + 15);
    check(rst_n_o == 1'b0, "R9 held off", rst_n_o, 0);
    check(cfg_o == 2'b00, "R11 reload", cfg_o, 0);
    @(negedge clk); por_rise = 1'b1; por_fall = 1'b1; c = cyc;
    push_ev(EV_REL, por_release(c), "R9 full por wait");
    push_ev(EV_RDY, por_release(c) + OW + 1, "R9 R3 ready");
    step(FILT + PW + OW + 12);

    // R12 other mode ignores LVD flags; R11 reload picks new option
    @(negedge clk);
    por_rise = 1'b0; por_fall = 1'b0; lvd_hi = 1'b0; lvd_lo = 1'b0; c = cyc;
    push_ev(EV_ASSERT, after_filter(c), "R9 power off");
    step(15);
    opt_mode = 2'b11; opt_lvl = 1'b1;
    step(3);
    check(cfg_o == 2'b11, "R11 new option", cfg_o, 3);
    power_up("R12 por release");
    lvd_hi = 1'b0; lvd_lo = 1'b0;
    step(30);
    check(rst_n_o == 1'b1 && cpu_rdy_o == 1'b1, "R12 flags ignored", {rst_n_o, cpu_rdy_o}, 3);

    step(5);
    check(exp_q.size() == 0, "missing events", exp_q.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule